// File: doc/BRIEF.md
# Configuration Restore Sequencer

This block brings a device's volatile settings back after power is applied. It follows a supply-detect flag and a lockout-cleared flag, and it steers the programmable outputs through three boot phases. With no supply the outputs float. Once a supply is seen they are weakly pulled to ground. After the restore they are driven from the stored setting.

The settings live in two stages of latches. The sequencer reads the non-volatile array one word per cycle and fills the first stage only. When the last word has landed, one global strobe copies the whole first stage into the second stage, which is the stage the device runs from. Until that strobe has completed, a busy flag tells the serial slave to refuse every transaction. After boot, a download command runs the same restore again. The device keeps its present setting until the new strobe, and then it returns to whatever the array holds.

A write port lets the array be changed offline. A registered read port exposes the second stage.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `supply_det` is low, from the next clock edge on, `pad_oe` is all zeros and `pad_weak_pd` is 0 (high impedance), `cfg_done` is 0 and `cfg_busy` is 1.
- R2: With supply present and no committed setting, `pad_weak_pd` is 1 and `pad_oe` is all zeros.
- R3: No array word reaches the second stage while `uvlo_ok` is low. Second-stage word 0 still reads 0 after reset when supply is present but lockout is not cleared.
- R4: The array is read from address 0 to DEPTH-1, one word per cycle. The second stage does not change except on the commit strobe.
- R5: `cfg_commit` is high for exactly one cycle. It is first seen after the (DEPTH+2)-th clock edge counted from the edge that samples `uvlo_ok` high (or `dl_cmd` high in the done state).
- R6: `cfg_done` rises in the cycle after `cfg_commit` and stays high until reset, supply loss or a download command. `cfg_busy` is its inverse.
- R7: Once committed, `pad_oe` is all ones and `pad_val` equals bits [NUM_OUT-1:0] of second-stage word 0.
- R8: `cfg_rd_data` returns second-stage word `cfg_rd_addr` one clock after the address is presented.
- R9: Array writes after boot change nothing until `dl_cmd`. During the re-download the pads keep the old setting, and after its commit the second stage holds the new array contents.
- R10: If `uvlo_ok` drops during a download, the next edge returns to the weak-low state with busy set. A later rise restarts from address 0 with the full R5 timing.
- R11: Losing supply after boot clears done and floats the outputs (R1 state).
- R12: `dl_cmd` asserted while a download is in progress is ignored and does not change the R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_det | input | 1 | Some supply input above the detect level |
| uvlo_ok | input | 1 | Supply above the lockout threshold |
| dl_cmd | input | 1 | Runtime re-download request |
| nv_wr_en | input | 1 | Offline write strobe to the non-volatile array |
| nv_wr_addr | input | $clog2(DEPTH) | Array write address |
| nv_wr_data | input | WIDTH | Array write data |
| cfg_rd_addr | input | $clog2(DEPTH) | Second-stage read address |
| cfg_rd_data | output | WIDTH | Second-stage read data, one cycle latency |
| pad_oe | output | NUM_OUT | Strong drive enable per output |
| pad_val | output | NUM_OUT | Driven value per output |
| pad_weak_pd | output | 1 | Weak pull-down on all outputs |
| cfg_commit | output | 1 | First-to-second stage transfer strobe |
| cfg_done | output | 1 | Restore complete |
| cfg_busy | output | 1 | Serial slave must NACK |

## Verification
A sequencer that skips or repeats an address leaves a second-stage word different from the programmed pattern, and a full readback sweep shows this right after the first commit. A wrong state count moves the commit strobe off the DEPTH+2 edge, which the edge counter catches on every boot, re-download and restart. A second stage that leaks early shows as pads or readback changing before the strobe, which is checked on every cycle of a re-download. A missed abort keeps busy low, or keeps the outputs driven, one edge after the lockout drops.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_LOAD,
    ST_FLUSH,
    ST_COMMIT,
    ST_DONE
  } boot_st_e;
endpackage

// File: rtl/cfg_nv_array.sv
module cfg_nv_array #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cfg_boot_fsm.sv
module cfg_boot_fsm
  import cfg_boot_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_det,
  input  logic          uvlo_ok,
  input  logic          dl_cmd,
  output logic          nv_rd_en,
  output logic [AW-1:0] nv_rd_addr,
  output logic          lat_wr_en,
  output logic [AW-1:0] lat_wr_addr,
  output logic          commit,
  output logic          done,
  output logic          cfg_valid,
  output logic          in_off
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  boot_st_e      state;
  logic [AW-1:0] cnt;
  logic          live;

  assign live        = supply_det && uvlo_ok;
  assign nv_rd_en    = (state == ST_LOAD) && live;
  assign nv_rd_addr  = cnt;
  assign commit      = (state == ST_COMMIT) && live;
  assign done        = (state == ST_DONE);
  assign in_off      = (state == ST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OFF;
      cnt         <= '0;
      lat_wr_en   <= 1'b0;
      lat_wr_addr <= '0;
      cfg_valid   <= 1'b0;
    end else begin
      lat_wr_en <= 1'b0;
      if (!supply_det) begin
        state     <= ST_OFF;
        cnt       <= '0;
        cfg_valid <= 1'b0;
      end else begin
        case (state)
          ST_OFF: state <= ST_WAIT;
          ST_WAIT: if (uvlo_ok) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
          ST_LOAD: begin
            if (!uvlo_ok) begin
              state     <= ST_WAIT;
              cnt       <= '0;
              cfg_valid <= 1'b0;
            end else begin
              lat_wr_en   <= 1'b1;
              lat_wr_addr <= cnt;
              if (cnt == LAST) state <= ST_FLUSH;
              else cnt <= cnt + AW'(1);
            end
          end
          ST_FLUSH: begin
            if (!uvlo_ok) begin
              state     <= ST_WAIT;
              cnt       <= '0;
              cfg_valid <= 1'b0;
            end else state <= ST_COMMIT;
          end
          ST_COMMIT: begin
            if (!uvlo_ok) begin
              state     <= ST_WAIT;
              cnt       <= '0;
              cfg_valid <= 1'b0;
            end else begin
              state     <= ST_DONE;
              cfg_valid <= 1'b1;
            end
          end
          ST_DONE: if (dl_cmd) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    nv_rd_en && $past(nv_rd_en) |-> nv_rd_addr == $past(nv_rd_addr) + AW'(1));
  // R6
  commit_done_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> done);
  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !dl_cmd && supply_det |=> done);
  // R5
  rose_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(commit));
endmodule

// File: rtl/cfg_latch_pair.sv
module cfg_latch_pair #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             commit,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] word0
);
  logic [WIDTH-1:0] a_q [DEPTH];
  logic [WIDTH-1:0] b_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        a_q[i] <= '0;
        b_q[i] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(i)) a_q[i] <= wr_data;
        if (commit) b_q[i] <= a_q[i];
      end
    end

    // R4
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !commit |=> $stable(b_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else rd_data <= b_q[rd_addr];
  end

  assign word0 = b_q[0];
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq #(
  parameter int DEPTH   = 8,
  parameter int WIDTH   = 8,
  parameter int NUM_OUT = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               supply_det,
  input  logic               uvlo_ok,
  input  logic               dl_cmd,
  input  logic               nv_wr_en,
  input  logic [AW-1:0]      nv_wr_addr,
  input  logic [WIDTH-1:0]   nv_wr_data,
  input  logic [AW-1:0]      cfg_rd_addr,
  output logic [WIDTH-1:0]   cfg_rd_data,
  output logic [NUM_OUT-1:0] pad_oe,
  output logic [NUM_OUT-1:0] pad_val,
  output logic               pad_weak_pd,
  output logic               cfg_commit,
  output logic               cfg_done,
  output logic               cfg_busy
);
  logic             rd_en, lat_we, cfg_valid, in_off;
  logic [AW-1:0]    rd_addr, lat_addr;
  logic [WIDTH-1:0] rd_data, word0;

  cfg_nv_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) nv_i (
    .clk(clk), .wr_en(nv_wr_en), .wr_addr(nv_wr_addr), .wr_data(nv_wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfg_boot_fsm #(.DEPTH(DEPTH)) fsm_i (
    .clk(clk), .rst(rst), .supply_det(supply_det), .uvlo_ok(uvlo_ok),
    .dl_cmd(dl_cmd), .nv_rd_en(rd_en), .nv_rd_addr(rd_addr),
    .lat_wr_en(lat_we), .lat_wr_addr(lat_addr), .commit(cfg_commit),
    .done(cfg_done), .cfg_valid(cfg_valid), .in_off(in_off)
  );

  cfg_latch_pair #(.DEPTH(DEPTH), .WIDTH(WIDTH)) lat_i (
    .clk(clk), .rst(rst), .wr_en(lat_we), .wr_addr(lat_addr),
    .wr_data(rd_data), .commit(cfg_commit), .rd_addr(cfg_rd_addr),
    .rd_data(cfg_rd_data), .word0(word0)
  );

  assign pad_oe      = {NUM_OUT{cfg_valid}};
  assign pad_val     = cfg_valid ? word0[NUM_OUT-1:0] : '0;
  assign pad_weak_pd = !in_off && !cfg_valid;
  assign cfg_busy    = !cfg_done;

  // R1
  off_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_det |=> (pad_oe == '0) && !pad_weak_pd && cfg_busy);
  // R2
  weak_low_chk: assert property (@(posedge clk) disable iff (rst)
    pad_weak_pd |-> pad_oe == '0);
endmodule

// File: tb/cfg_boot_seq_tb.sv
module cfg_boot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int NOUT  = 4;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_det = 1'b0, uvlo_ok = 1'b0, dl_cmd = 1'b0;
  logic nv_wr_en = 1'b0;
  logic [AW-1:0] nv_wr_addr = '0, cfg_rd_addr = '0;
  logic [WIDTH-1:0] nv_wr_data = '0;
  logic [WIDTH-1:0] cfg_rd_data;
  logic [NOUT-1:0] pad_oe, pad_val;
  logic pad_weak_pd, cfg_commit, cfg_done, cfg_busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_boot_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NUM_OUT(NOUT)) dut_i (
    .clk(clk), .rst(rst), .supply_det(supply_det), .uvlo_ok(uvlo_ok),
    .dl_cmd(dl_cmd), .nv_wr_en(nv_wr_en), .nv_wr_addr(nv_wr_addr),
    .nv_wr_data(nv_wr_data), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .pad_oe(pad_oe), .pad_val(pad_val),
    .pad_weak_pd(pad_weak_pd), .cfg_commit(cfg_commit),
    .cfg_done(cfg_done), .cfg_busy(cfg_busy)
  );

  function automatic logic [WIDTH-1:0] pat(input int set, input int i);
    case (set)
      0: return WIDTH'((i * 37 + 5) & 255);
      1: return WIDTH'((i * 91 + 200) & 255);
      default: return WIDTH'(((i * 13) ^ 8'hA5) & 255);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic program_nv(input int set);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      nv_wr_en = 1'b1; nv_wr_addr = AW'(i); nv_wr_data = pat(set, i);
    end
    @(negedge clk);
    nv_wr_en = 1'b0;
  endtask

  task automatic read_b(input int a, output int v);
    @(negedge clk);
    cfg_rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    v = int'(cfg_rd_data);
  endtask

  task automatic sweep_b(input string req, input int set);
    int v;
    for (int i = 0; i < DEPTH; i++) begin
      read_b(i, v);
      chk(v == int'(pat(set, i)), req, v, int'(pat(set, i)));
    end
  endtask

  // Caller sets the trigger at a negedge, then calls. dl_cmd is driven high
  // only when the edge count equals dl_at; pad_hold checks the old setting.
  task automatic run_commit(input int dl_at, input bit pad_hold,
                            input int old_val, output int n);
    int pulses;
    n = 0; pulses = 0;
    while (n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      dl_cmd = (n == dl_at);
      if (pad_hold && !cfg_commit)
        chk(pad_oe == '1 && int'(pad_val) == old_val, "R9 pads hold", int'(pad_val), old_val);
      if (cfg_commit) break;
    end
    @(posedge clk);
    @(negedge clk);
    chk(!cfg_commit, "R5 single strobe", int'(cfg_commit), 0);
    chk(cfg_done && !cfg_busy, "R6 done after strobe", int'(cfg_done), 1);
  endtask

  initial begin
    int n, v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset / no supply
    chk(pad_oe == '0 && !pad_weak_pd, "R1 hi-Z", int'(pad_weak_pd), 0);
    chk(!cfg_done && cfg_busy, "R1 busy", int'(cfg_busy), 1);
    program_nv(0);

    supply_det = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(pad_weak_pd && pad_oe == '0, "R2 weak low", int'(pad_weak_pd), 1);
    repeat (5) begin
      @(negedge clk);
      chk(!cfg_commit && cfg_busy, "R3 idle before lockout", int'(cfg_commit), 0);
    end
    read_b(0, v);
    chk(v == 0, "R3 no load before lockout", v, 0);

    uvlo_ok = 1'b1;
    run_commit(0, 1'b0, 0, n);
    chk(n == DEPTH + 2, "R5 boot timing", n, DEPTH + 2);
    chk(pad_oe == '1 && !pad_weak_pd, "R7 pads driven", int'(pad_oe), (1 << NOUT) - 1);
    chk(int'(pad_val) == int'(pat(0, 0)) % (1 << NOUT), "R7 pad value",
        int'(pad_val), int'(pat(0, 0)) % (1 << NOUT));
    sweep_b("R4 R8 boot contents", 0);
    repeat (4) @(negedge clk);
    chk(cfg_done, "R6 done holds", int'(cfg_done), 1);

    // R9 offline change, then re-download
    program_nv(1);
    sweep_b("R9 unchanged before cmd", 0);
    @(negedge clk);
    dl_cmd = 1'b1;
    run_commit(0, 1'b1, int'(pat(0, 0)) % (1 << NOUT), n);
    chk(n == DEPTH + 2, "R5 R9 redownload timing", n, DEPTH + 2);
    sweep_b("R9 new contents", 1);
    chk(int'(pad_val) == int'(pat(1, 0)) % (1 << NOUT), "R9 pads new",
        int'(pad_val), int'(pat(1, 0)) % (1 << NOUT));

    // R11 supply loss
    @(negedge clk);
    supply_det = 1'b0; uvlo_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(pad_oe == '0 && !pad_weak_pd, "R11 hi-Z after loss", int'(pad_oe), 0);
    chk(!cfg_done && cfg_busy, "R11 done cleared", int'(cfg_done), 0);

    // R12 dl_cmd during boot ignored
    supply_det = 1'b1;
    repeat (2) @(negedge clk);
    uvlo_ok = 1'b1;
    run_commit(3, 1'b0, 0, n);
    chk(n == DEPTH + 2, "R12 dl_cmd ignored", n, DEPTH + 2);

    // R10 abort and restart
    program_nv(2);
    @(negedge clk);
    dl_cmd = 1'b1;
    @(posedge clk); @(negedge clk);
    dl_cmd = 1'b0;
    repeat (3) @(negedge clk);
    uvlo_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(pad_weak_pd && pad_oe == '0, "R10 weak low on abort", int'(pad_weak_pd), 1);
    chk(cfg_busy && !cfg_done, "R10 busy on abort", int'(cfg_busy), 1);
    repeat (2) @(negedge clk);
    uvlo_ok = 1'b1;
    run_commit(0, 1'b0, 0, n);
    chk(n == DEPTH + 2, "R10 restart timing", n, DEPTH + 2);
    sweep_b("R10 restart contents", 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule